// File: doc/BRIEF.md
# Serial Audio Link Frame Controller

This block is the controller end of a serial audio codec link, clocked only by the bit clock that the codec supplies. It issues a frame marker, shifts out a 256-bit outgoing frame that carries control words and playback data, and collects 256-bit incoming frames from a primary codec and an optional secondary codec. The codec-ready flag, bit 15 of each incoming tag slot, is combined from both inputs. Software logic around the block exchanges whole frames through parallel registers. The outgoing frame is taken at each frame boundary, and the received frames are presented at that same boundary together with a one-cycle strobe.

The marker and data-out pins also act as boot-option straps. While reset is held, both drivers are released and weak pull-ups are switched on. The first bit-clock edge after reset is released latches both pin levels into a 2-bit option value, which then stays fixed until the next reset. Each frame has a 16-bit tag slot followed by twelve 20-bit slots. A frame is written as a 256-bit vector whose bit 255 is the first bit on the wire. The tag occupies bits 255..240, and slot n (n = 0..11) occupies bits 239-20n down to 220-20n.

Top module: `acl_ctrl`

## Requirements
- R1: While `rst_n` is low, `pins_oe_o` is 0, `pull_en_o` is 1, `frame_done_o` is 0, and `sync_o` and `sdout_o` are 0.
- R2: At the first rising `bclk` edge after `rst_n` goes high, `strap_o[1]` takes `sdout_pad_i` and `strap_o[0]` takes `sync_pad_i`. `strap_o` then stays unchanged until the next reset, whatever the pads do.
- R3: For the one bit clock that follows the strap capture, `pins_oe_o` is 1 and both `sync_o` and `sdout_o` are 0. Framing starts at the next rising edge.
- R4: Each frame lasts exactly 256 bit clocks. `sync_o` is high for the first 16 of them and low for the other 240.
- R5: `sdout_o` changes on rising edges. It sends the frame MSB first, starting with bit 255 in the bit clock where `sync_o` first goes high. Its content is `tx_frame_i` as sampled on the rising edge that starts that frame.
- R6: Both serial inputs are sampled on falling edges. The bit present during bit clock k of a frame (k = 0 at the rise of `sync_o`) lands in bit 255-k of the received frame.
- R7: `frame_done_o` pulses for exactly one bit clock, in the first bit clock of the next frame, and `sync_o` is high during that pulse. `rx_pri_o` and `rx_sec_o` update in that same cycle. No pulse occurs before the first complete frame.
- R8: `rx_sec_o` takes the secondary frame only if `sec_en_i` is 1 at the frame boundary. If `sec_en_i` is 0, `rx_sec_o` becomes all zeros and the secondary input has no effect on any output.
- R9: `codec_ready_o` equals bit 255 of the received primary frame ORed with bit 255 of the received secondary frame. It changes only together with `frame_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pad_i | input | 1 | Level read back from the marker pin, used as strap bit 0 |
| sdout_pad_i | input | 1 | Level read back from the data-out pin, used as strap bit 1 |
| sdin_pri_i | input | 1 | Serial data from the primary codec |
| sdin_sec_i | input | 1 | Serial data from the secondary codec |
| sec_en_i | input | 1 | Enables use of the secondary input |
| tx_frame_i | input | 256 | Next outgoing frame, with bit 255 sent first |
| sync_o | output | 1 | Frame marker |
| sdout_o | output | 1 | Serial data to the codec |
| pins_oe_o | output | 1 | Output enable for the marker and data-out pins |
| pull_en_o | output | 1 | Weak pull-up enable for the same pins |
| strap_o | output | 2 | Latched boot-option value |
| rx_pri_o | output | 256 | Last complete frame from the primary codec |
| rx_sec_o | output | 256 | Last complete frame from the secondary codec, or zero when disabled |
| codec_ready_o | output | 1 | Merged codec-ready flag |
| frame_done_o | output | 1 | One-cycle strobe at each frame boundary |

## Verification
The assertions assume that `bclk` runs without gaps. They also assume that `tx_frame_i` and `sec_en_i` are stable at the rising edge that closes a frame, and that the codec changes its serial data only just after rising edges, so a value is settled before the falling edge that samples it. The stimulus follows these rules. Serial bits are driven one nanosecond after each rising edge. The outgoing frame and the secondary enable are changed only at mid-frame, at bit clock 128. Reset is released between edges. The pads are also changed after the strap capture, to show that the latched value does not move.

// File: rtl/acl_pkg.sv
package acl_pkg;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int NSLOT   = 12;
  localparam int FRAME_W = TAG_W + SLOT_W * NSLOT;
  localparam int CNT_W   = $clog2(FRAME_W);

  // true while the bit position lies in the tag slot (marker high)
  function automatic logic in_tag(input logic [CNT_W:0] pos);
    return pos < (CNT_W+1)'(TAG_W);
  endfunction

  // wire bit k of a frame maps to vector bit FRAME_W-1-k
  function automatic int wire_to_vec(input int k);
    return FRAME_W - 1 - k;
  endfunction
endpackage

// File: rtl/acl_strap.sv
module acl_strap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_pad_i,
  input  logic       sdout_pad_i,
  output logic       in_reset_o,
  output logic [1:0] strap_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_reset_o <= 1'b1;
    else        in_reset_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          strap_o <= 2'b00;
    else if (in_reset_o) strap_o <= {sdout_pad_i, sync_pad_i};
  end

  // straps never move once the capture edge has passed
  assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_reset_o |=> $stable(strap_o));
endmodule

// File: rtl/acl_tx.sv
module acl_tx #(
  parameter int W = acl_pkg::FRAME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] frame_i,
  output logic         sd_o
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh <= '0;
    else if (load_i)  sh <= frame_i;
    else if (shift_i) sh <= {sh[W-2:0], 1'b0};
  end

  assign sd_o = sh[W-1];
endmodule

// File: rtl/acl_rx.sv
module acl_rx #(
  parameter int W = acl_pkg::FRAME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         sdin_i,
  input  logic         done_i,
  output logic [W-1:0] frame_o
);
  logic         smp;
  logic [W-1:0] sh;

  // falling-edge sample of the codec line
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) smp <= 1'b0;
    else        smp <= sdin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[W-2:0], smp};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frame_o <= '0;
    else if (done_i) frame_o <= en_i ? {sh[W-2:0], smp} : '0;
  end
endmodule

// File: rtl/acl_ctrl.sv
module acl_ctrl
  import acl_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          sync_pad_i,
  input  logic          sdout_pad_i,
  input  logic          sdin_pri_i,
  input  logic          sdin_sec_i,
  input  logic          sec_en_i,
  input  logic [FW-1:0] tx_frame_i,
  output logic          sync_o,
  output logic          sdout_o,
  output logic          pins_oe_o,
  output logic          pull_en_o,
  output logic [1:0]    strap_o,
  output logic [FW-1:0] rx_pri_o,
  output logic [FW-1:0] rx_sec_o,
  output logic          codec_ready_o,
  output logic          frame_done_o
);
  localparam int CW = $clog2(FW);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);

  logic          in_reset;
  logic          run;
  logic [CW-1:0] cnt;
  logic          sync_q;
  logic          tx_load;
  logic          boundary;
  logic          start;

  // named internal events
  assign start    = !in_reset && !run;
  assign boundary = run && (cnt == LAST);
  assign tx_load  = start || boundary;

  acl_strap u_strap (
    .clk(bclk), .rst_n(rst_n), .sync_pad_i(sync_pad_i),
    .sdout_pad_i(sdout_pad_i), .in_reset_o(in_reset), .strap_o(strap_o)
  );

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= boundary ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)       sync_q <= 1'b0;
    else if (tx_load) sync_q <= 1'b1;
    else              sync_q <= run && in_tag({1'b0, cnt} + 1'b1);
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) frame_done_o <= 1'b0;
    else        frame_done_o <= boundary;
  end

  acl_tx #(.W(FW)) u_tx (
    .clk(bclk), .rst_n(rst_n), .load_i(tx_load), .shift_i(run),
    .frame_i(tx_frame_i), .sd_o(sdout_o)
  );

  acl_rx #(.W(FW)) u_rx_pri (
    .clk(bclk), .rst_n(rst_n), .en_i(1'b1), .sdin_i(sdin_pri_i),
    .done_i(boundary), .frame_o(rx_pri_o)
  );

  acl_rx #(.W(FW)) u_rx_sec (
    .clk(bclk), .rst_n(rst_n), .en_i(sec_en_i), .sdin_i(sdin_sec_i),
    .done_i(boundary), .frame_o(rx_sec_o)
  );

  assign sync_o        = sync_q;
  assign pins_oe_o     = !in_reset;
  assign pull_en_o     = in_reset;
  assign codec_ready_o = rx_pri_o[FW-1] | rx_sec_o[FW-1];

  assert_done_in_tag_R7: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_done_o |-> sync_o);
  assert_done_single_R7: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  assert_sync_with_load_R5: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(tx_load));
  assert_ready_at_boundary_R9: assert property (@(posedge bclk) disable iff (!rst_n)
    $changed(codec_ready_o) |-> frame_done_o);
  assert_quiet_before_frame_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    !run |-> !sync_o && !sdout_o);
endmodule

// File: tb/tb_acl_ctrl.sv
module tb_acl_ctrl;
  localparam int FW = 256;

  logic bclk = 0;
  logic rst_n = 0;
  logic sync_pad_i = 0, sdout_pad_i = 0;
  logic sdin_pri_i = 0, sdin_sec_i = 0, sec_en_i = 0;
  logic [FW-1:0] tx_frame_i = '0;
  logic sync_o, sdout_o, pins_oe_o, pull_en_o, codec_ready_o, frame_done_o;
  logic [1:0] strap_o;
  logic [FW-1:0] rx_pri_o, rx_sec_o;

  acl_ctrl dut (.*);

  always #10 bclk = ~bclk;

  int n_chk = 0, n_bad = 0;
  int bcnt = 999, fidx = 0, n_done = 0;
  logic sync_prev = 0;
  logic [FW-1:0] pri_cur, sec_cur, tx_bits;
  logic sync_bad;
  logic [FW-1:0] q_pri[$], q_sec[$], q_tx[$];
  logic q_rdy[$];

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] pat(input int k, input int salt);
    logic [FW-1:0] v;
    for (int i = 0; i < FW/32; i++) v[i*32 +: 32] = 32'h9E37_79B9 * (k*8 + i + salt) ^ 32'h5A5A_0F0F;
    return v;
  endfunction

  // driver: codec model and expected-item producer
  always @(posedge bclk) begin
    #1;
    if (!rst_n) begin
      bcnt = 999; sync_prev = 0;
    end else begin
      if (sync_o && !sync_prev) begin
        if (bcnt != 255 && bcnt != 999) check("R4 frame length", bcnt, 255);
        bcnt = 0;
      end else if (bcnt < 999) bcnt++;
      sync_prev = sync_o;
      if (bcnt == 0) begin
        pri_cur = pat(fidx, 1); sec_cur = pat(fidx, 7);
        pri_cur[FW-1] = (fidx % 4 == 0);
        sec_cur[FW-1] = (fidx % 4 == 1) || (fidx % 4 == 3);
      end
      if (bcnt < FW) begin
        sdin_pri_i = pri_cur[FW-1-bcnt];
        sdin_sec_i = sec_cur[FW-1-bcnt];
      end
      if (bcnt == 128) begin
        sec_en_i = (fidx % 3 != 0);
        tx_frame_i = pat(fidx, 33);
        q_tx.push_back(tx_frame_i);
      end
      if (bcnt == 255) begin
        q_pri.push_back(pri_cur);
        q_sec.push_back(sec_en_i ? sec_cur : '0);
        q_rdy.push_back(pri_cur[FW-1] | (sec_en_i & sec_cur[FW-1]));
        fidx++;
      end
    end
  end

  // monitor: sampled on falling edges
  always @(negedge bclk) begin
    if (rst_n && bcnt < FW) begin
      if (bcnt == 0) sync_bad = 0;
      if (sync_o !== (bcnt < 16)) sync_bad = 1;
      tx_bits[FW-1-bcnt] = sdout_o;
      if (bcnt == 255) begin
        check("R4 sync window", sync_bad, 0);
        if (q_tx.size() > 0) check("R5 serial out", tx_bits, q_tx.pop_front());
        else check("R5 tx queue empty", 1, 0);
      end
      if (frame_done_o) begin
        n_done++;
        check("R7 done in first bit", bcnt, 0);
        if (q_pri.size() > 0) begin
          check("R6 primary frame", rx_pri_o, q_pri.pop_front());
          check("R8 secondary frame", rx_sec_o, q_sec.pop_front());
          check("R9 ready merge", codec_ready_o, q_rdy.pop_front());
        end else check("R7 unexpected done", 1, 0);
      end
    end
  end

  task automatic reset_and_start(input logic [1:0] strap);
    rst_n = 0;
    q_pri.delete(); q_sec.delete(); q_tx.delete(); q_rdy.delete();
    sdout_pad_i = strap[1]; sync_pad_i = strap[0];
    @(negedge bclk); @(negedge bclk);
    check("R1 oe off", pins_oe_o, 0);
    check("R1 pull on", pull_en_o, 1);
    check("R1 outputs quiet", {frame_done_o, sync_o, sdout_o}, 0);
    q_tx.push_back(tx_frame_i);
    #5 rst_n = 1;
    @(negedge bclk);
    check("R2 strap capture", strap_o, strap);
    check("R3 pins driven low", {pins_oe_o, sync_o, sdout_o}, 3'b100);
    sdout_pad_i = ~strap[1]; sync_pad_i = ~strap[0];
  endtask

  initial begin
    reset_and_start(2'b10);
    while (n_done < 7) @(negedge bclk);
    check("R2 strap held", strap_o, 2'b10);
    repeat (100) @(negedge bclk);
    reset_and_start(2'b01);
    while (n_done < 11) @(negedge bclk);
    check("R2 strap held", strap_o, 2'b01);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=11 frames", n_done);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule